// File: doc/BRIEF.md
# Opcode-Driven SPI Transfer Sequencer

This block is a half-duplex SPI master that executes a queue of micro-commands rather than a set of transfer registers. Each 14-bit command word combines a 5-bit opcode with a 9-bit byte count. The opcode chooses one of four actions: drive chip select inactive, drive it active, shift bytes out on one, two or four data lines, or shift bytes in on one, two or four lines. A further family of opcodes transmits and then turns the data pins around so that a following read can sample them.

The host fills a command queue and a byte queue through strobed write ports and polls their full and empty flags. The byte queue is shared. Transmit commands drain it and receive commands fill it. The command queue reports empty only once the last queued command has completed, so polling for an empty command queue tells the host that the work is done. The serial clock idles low. Output lines change while the clock is low. Input lines are sampled at the end of the high phase.

Top module: `spi_opseq`

## Requirements
- R1: After a synchronous reset, spi_cs_n is 1, io_oe is 0, spi_sck is 0, and both cmd_empty and dat_empty are 1.
- R2: A command word holds the opcode in bits 13..9 and the byte count in bits 8..0. Opcode 0x00 sets spi_cs_n to 1 and opcode 0x01 sets it to 0. spi_cs_n holds its value while a transfer runs.
- R3: Opcodes 0x08, 0x09 and 0x0A each send count bytes from the byte queue, most significant bit first. Opcode 0x08 uses one line (io_out[0], io_oe=0001), 0x09 uses two (io_out[1:0], io_oe=0011) and 0x0A uses four (io_out[3:0], io_oe=1111). The highest-numbered line carries the most significant bit of each group, and the data is valid at each rising edge of spi_sck. After a plain send, io_oe keeps its value.
- R4: Opcodes 0x0C, 0x0E and 0x0F each receive count bytes into the byte queue, most significant bit first. Opcode 0x0C reads io_in[1], 0x0E reads io_in[1:0] and 0x0F reads io_in[3:0]. Input is sampled at the end of each high phase of spi_sck.
- R5: Opcodes 0x10 to 0x18 send data on a lane width of (op-0x10)/3, where 0 means one line, 1 means two lines and 2 means four lines. io_oe then goes to 0 when the last byte completes.
- R6: cmd_full is 1 when 4 commands are queued, and a push while the queue is full is ignored. cmd_empty stays 0 until the last queued command has completed.
- R7: A send command whose byte queue is empty holds spi_sck at 0 until a byte arrives.
- R8: A receive command holds spi_sck at 0 while the byte queue (depth 4) is full, and no received byte is lost.
- R9: Any other opcode is consumed with no clock pulses and no change to chip select. A send or receive command with a count of 0 is consumed without moving any data.
- R10: io_oe is 0 during a receive. Host byte pushes are ignored while a receive command runs, and host pops are ignored while a send command runs.
- R11: A host pop and a byte completed by the receiver in the same cycle both take effect, and the bytes stay in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wdata | input | 14 | Command word to queue |
| cmd_push | input | 1 | Push strobe for the command queue |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | No command pending or executing |
| dat_wdata | input | 8 | Byte to queue for sending |
| dat_push | input | 1 | Push strobe for the byte queue |
| dat_full | output | 1 | Byte queue full |
| dat_empty | output | 1 | Byte queue empty |
| dat_rdata | output | 8 | Head of the byte queue |
| dat_pop | input | 1 | Pop strobe for the byte queue |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The byte queue can receive a completed byte from the receiver and a host pop in the same cycle. A receive of six bytes on four lines completes one byte every five cycles. The bench pops one byte every five cycles and sweeps the pop phase over all five offsets, so that at least one run lines up a pop with the receiver's write. Each run is judged on whether all six bytes come back in order with nothing extra left behind. The stall paths are judged separately by watching spi_sck stay low while the queue blocks progress.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;
    localparam int CMD_W = 14;
    localparam int OP_W  = 5;
    localparam int LEN_W = 9;

    typedef enum logic [2:0] {K_NOP, K_CS_HI, K_CS_LO, K_SEND, K_RECV} kind_t;
    typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lane_t;

    typedef struct packed {
        kind_t kind;
        lane_t lane;
        logic  turn;
    } dec_t;

    function automatic dec_t decode(input logic [OP_W-1:0] op);
        dec_t d;
        d.kind = K_NOP;
        d.lane = LN1;
        d.turn = 1'b0;
        if (op == 5'h00) d.kind = K_CS_HI;
        else if (op == 5'h01) d.kind = K_CS_LO;
        else if (op >= 5'h08 && op <= 5'h0A) begin
            d.kind = K_SEND;
            d.lane = lane_t'(2'(op - 5'h08));
        end else if (op == 5'h0C) begin
            d.kind = K_RECV;
            d.lane = LN1;
        end else if (op == 5'h0E) begin
            d.kind = K_RECV;
            d.lane = LN2;
        end else if (op == 5'h0F) begin
            d.kind = K_RECV;
            d.lane = LN4;
        end else if (op >= 5'h10 && op <= 5'h18) begin
            d.kind = K_SEND;
            d.turn = 1'b1;
            d.lane = lane_t'(2'((op - 5'h10) / 3));
        end
        return d;
    endfunction

    function automatic logic [3:0] lane_mask(input lane_t l);
        case (l)
            LN2:     return 4'b0011;
            LN4:     return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction
endpackage

// File: rtl/spi_opseq_fifo.sv
module spi_opseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic [AW:0]  used;

    assign used  = wp - rp;
    assign full  = (used == (AW+1)'(DEPTH));
    assign empty = (wp == rp);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                mem[wp[AW-1:0]] <= wdata;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        used <= (AW+1)'(DEPTH));
endmodule

// File: rtl/spi_opseq_engine.sv
module spi_opseq_engine
    import spi_opseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_head,
    input  logic             cmd_empty,
    output logic             cmd_pop,
    input  logic [7:0]       dat_head,
    input  logic             dat_empty,
    input  logic             dat_full,
    output logic             dat_pop,
    output logic             dat_push,
    output logic [7:0]       dat_push_data,
    output logic             tx_active,
    output logic             rx_active,
    output logic             sck,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} st_t;

    st_t              state;
    logic [LEN_W-1:0] cnt;
    logic [3:0]       steps;
    logic             busy;
    logic [7:0]       shreg;
    logic             turn_q;
    lane_t            lane_q;
    dec_t             dec;
    logic [LEN_W-1:0] head_len;
    logic [7:0]       tx_next, rx_next;
    logic             last_edge;

    assign dec       = decode(cmd_head[CMD_W-1:LEN_W]);
    assign head_len  = cmd_head[LEN_W-1:0];
    assign tx_active = (state == ST_TX);
    assign rx_active = (state == ST_RX);
    assign last_edge = busy && sck && (steps == 4'd1);

    always_comb begin
        case (lane_q)
            LN2: begin
                tx_next = {shreg[5:0], 2'b00};
                rx_next = {shreg[5:0], io_in[1:0]};
                io_out  = {2'b00, shreg[7:6]};
            end
            LN4: begin
                tx_next = {shreg[3:0], 4'b0000};
                rx_next = {shreg[3:0], io_in[3:0]};
                io_out  = shreg[7:4];
            end
            default: begin
                tx_next = {shreg[6:0], 1'b0};
                rx_next = {shreg[6:0], io_in[1]};
                io_out  = {3'b000, shreg[7]};
            end
        endcase
    end

    always_comb begin
        cmd_pop       = 1'b0;
        dat_pop       = 1'b0;
        dat_push      = 1'b0;
        dat_push_data = rx_next;
        case (state)
            ST_IDLE: if (!cmd_empty) begin
                if (dec.kind == K_SEND || dec.kind == K_RECV)
                    cmd_pop = (head_len == '0);
                else
                    cmd_pop = 1'b1;
            end
            ST_TX: begin
                if (!busy && !dat_empty) dat_pop = 1'b1;
                if (last_edge && cnt == LEN_W'(1)) cmd_pop = 1'b1;
            end
            ST_RX: if (last_edge) begin
                dat_push = 1'b1;
                if (cnt == LEN_W'(1)) cmd_pop = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            steps  <= '0;
            busy   <= 1'b0;
            shreg  <= '0;
            turn_q <= 1'b0;
            lane_q <= LN1;
            sck    <= 1'b0;
            cs_n   <= 1'b1;
            io_oe  <= 4'b0000;
        end else begin
            case (state)
                ST_IDLE: if (!cmd_empty) begin
                    case (dec.kind)
                        K_CS_HI: cs_n <= 1'b1;
                        K_CS_LO: cs_n <= 1'b0;
                        K_SEND: if (head_len != '0) begin
                            state  <= ST_TX;
                            cnt    <= head_len;
                            lane_q <= dec.lane;
                            turn_q <= dec.turn;
                            io_oe  <= lane_mask(dec.lane);
                            busy   <= 1'b0;
                        end
                        K_RECV: if (head_len != '0) begin
                            state  <= ST_RX;
                            cnt    <= head_len;
                            lane_q <= dec.lane;
                            turn_q <= 1'b0;
                            io_oe  <= 4'b0000;
                            busy   <= 1'b0;
                        end
                        default: ;
                    endcase
                end
                ST_TX, ST_RX: begin
                    if (!busy) begin
                        if ((state == ST_TX) ? !dat_empty : !dat_full) begin
                            busy  <= 1'b1;
                            steps <= 4'(8 >> lane_q);
                            shreg <= (state == ST_TX) ? dat_head : 8'h00;
                        end
                    end else if (!sck) begin
                        sck <= 1'b1;
                    end else begin
                        sck   <= 1'b0;
                        shreg <= (state == ST_TX) ? tx_next : rx_next;
                        steps <= steps - 1'b1;
                        if (steps == 4'd1) begin
                            busy <= 1'b0;
                            cnt  <= cnt - 1'b1;
                            if (cnt == LEN_W'(1)) begin
                                state <= ST_IDLE;
                                if (turn_q) io_oe <= 4'b0000;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_halfduplex_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX) |-> (io_oe == 4'b0000));
    assert_tx_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && !busy && dat_empty) |=> !sck);
    assert_rx_room_R8: assert property (@(posedge clk) disable iff (rst)
        dat_push |-> !dat_full);
    assert_cmd_pop_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_pop |-> !cmd_empty);
    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(cs_n));
endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
    import spi_opseq_pkg::*;
#(
    parameter int CDEPTH = 4,
    parameter int DDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             cmd_push,
    output logic             cmd_full,
    output logic             cmd_empty,
    input  logic [7:0]       dat_wdata,
    input  logic             dat_push,
    output logic             dat_full,
    output logic             dat_empty,
    output logic [7:0]       dat_rdata,
    input  logic             dat_pop,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    logic [CMD_W-1:0] cmd_head;
    logic             cmd_pop;
    logic             e_pop, e_push, tx_act, rx_act;
    logic [7:0]       e_data;
    logic             q_push, q_pop;
    logic [7:0]       q_wdata;

    assign q_push  = e_push | (dat_push & !rx_act);
    assign q_wdata = e_push ? e_data : dat_wdata;
    assign q_pop   = e_pop | (dat_pop & !tx_act);

    spi_opseq_fifo #(.W(CMD_W), .DEPTH(CDEPTH)) u_cmdq (
        .clk(clk), .rst(rst), .push(cmd_push), .wdata(cmd_wdata),
        .pop(cmd_pop), .rdata(cmd_head), .full(cmd_full), .empty(cmd_empty)
    );

    spi_opseq_fifo #(.W(8), .DEPTH(DDEPTH)) u_datq (
        .clk(clk), .rst(rst), .push(q_push), .wdata(q_wdata),
        .pop(q_pop), .rdata(dat_rdata), .full(dat_full), .empty(dat_empty)
    );

    spi_opseq_engine u_eng (
        .clk(clk), .rst(rst),
        .cmd_head(cmd_head), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .dat_head(dat_rdata), .dat_empty(dat_empty), .dat_full(dat_full),
        .dat_pop(e_pop), .dat_push(e_push), .dat_push_data(e_data),
        .tx_active(tx_act), .rx_active(rx_act),
        .sck(spi_sck), .cs_n(spi_cs_n), .io_out(io_out), .io_oe(io_oe),
        .io_in(io_in)
    );
endmodule

// File: tb/sim_spi_opseq.sv
`timescale 1ns/1ps
module sim_spi_opseq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cmd_wdata = '0;
    logic        cmd_push = 1'b0;
    logic        cmd_full, cmd_empty;
    logic [7:0]  dat_wdata = '0;
    logic        dat_push = 1'b0;
    logic        dat_full, dat_empty;
    logic [7:0]  dat_rdata;
    logic        dat_pop = 1'b0;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  io_out, io_oe, io_in;

    int checks = 0;
    int fails = 0;
    int rises = 0;
    int nlog = 0;
    logic [3:0] slog [64];
    int g = 0;
    int rx_w = 0;
    logic [7:0] rx_pat [8];

    always #10 clk = ~clk;

    spi_opseq u0 (
        .clk(clk), .rst(rst), .cmd_wdata(cmd_wdata), .cmd_push(cmd_push),
        .cmd_full(cmd_full), .cmd_empty(cmd_empty), .dat_wdata(dat_wdata),
        .dat_push(dat_push), .dat_full(dat_full), .dat_empty(dat_empty),
        .dat_rdata(dat_rdata), .dat_pop(dat_pop), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    always @(posedge spi_sck) begin
        rises = rises + 1;
        if (io_oe != 4'b0000 && nlog < 64) begin
            slog[nlog] = io_out;
            nlog = nlog + 1;
        end
    end

    always @(negedge spi_sck) g = g + 1;

    always_comb begin
        int per, k, L;
        logic [7:0] b;
        logic [3:0] grp;
        L   = 1 << rx_w;
        per = 8 >> rx_w;
        b   = rx_pat[(g / per) % 8];
        k   = g % per;
        grp = 4'((b >> (8 - (k + 1) * L)) & ((1 << L) - 1));
        if (rx_w == 0) io_in = {2'b00, grp[0], 1'b0};
        else io_in = grp;
    end

    // opcode(5) | byte(8)
    localparam logic [12:0] TXV [6] = '{
        {5'h08, 8'hA5}, {5'h09, 8'h3C}, {5'h0A, 8'hE1},
        {5'h10, 8'h96}, {5'h14, 8'h5A}, {5'h18, 8'hC3}
    };
    localparam logic [12:0] RXV [3] = '{
        {5'h0C, 8'h5B}, {5'h0E, 8'hA7}, {5'h0F, 8'h3E}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [4:0] op, input logic [8:0] len);
        @(negedge clk);
        while (cmd_full) @(negedge clk);
        cmd_wdata = {op, len};
        cmd_push  = 1'b1;
        @(negedge clk);
        cmd_push  = 1'b0;
    endtask

    task automatic push_dat(input logic [7:0] b);
        @(negedge clk);
        while (dat_full) @(negedge clk);
        dat_wdata = b;
        dat_push  = 1'b1;
        @(negedge clk);
        dat_push  = 1'b0;
    endtask

    task automatic pop_dat(output logic [7:0] b);
        @(negedge clk);
        while (dat_empty) @(negedge clk);
        b = dat_rdata;
        dat_pop = 1'b1;
        @(negedge clk);
        dat_pop = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!cmd_empty) @(negedge clk);
    endtask

    function automatic int wof(input int op);
        return (op < 16) ? op - 8 : (op - 16) / 3;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1 && io_oe == 4'b0 && spi_sck == 1'b0, "R1", {spi_cs_n, io_oe, spi_sck}, 6'b100000);
        check(cmd_empty && dat_empty, "R1", {cmd_empty, dat_empty}, 2'b11);

        // R2 chip select opcodes
        push_cmd(5'h01, 9'd1); wait_done();
        check(spi_cs_n == 1'b0, "R2", spi_cs_n, 0);

        // table of send vectors (R3, R5)
        for (int i = 0; i < 6; i++) begin
            int w, L;
            logic [7:0] got;
            logic [3:0] mask;
            w = wof(int'(TXV[i][12:8]));
            L = 1 << w;
            mask = (w == 0) ? 4'b0001 : (w == 1) ? 4'b0011 : 4'b1111;
            nlog = 0;
            push_dat(TXV[i][7:0]);
            push_cmd(TXV[i][12:8], 9'd1);
            wait_done();
            got = '0;
            for (int j = 0; j < nlog; j++) got = 8'((got << L) | (slog[j] & mask));
            check(nlog == (8 >> w) && got == TXV[i][7:0], TXV[i][12:8] >= 5'h10 ? "R5" : "R3", got, TXV[i][7:0]);
            if (TXV[i][12:8] >= 5'h10) check(io_oe == 4'b0000, "R5", io_oe, 0);
            else check(io_oe == mask, "R3", io_oe, mask);
        end

        // table of receive vectors (R4)
        for (int i = 0; i < 3; i++) begin
            rx_w = wof(int'(TXV[0][12:8]));
            rx_w = (RXV[i][12:8] == 5'h0C) ? 0 : (RXV[i][12:8] == 5'h0E) ? 1 : 2;
            for (int j = 0; j < 8; j++) rx_pat[j] = RXV[i][7:0];
            g = 0;
            push_cmd(RXV[i][12:8], 9'd1);
            wait_done();
            check(io_oe == 4'b0000, "R10", io_oe, 0);
            pop_dat(b);
            check(b == RXV[i][7:0], "R4", b, RXV[i][7:0]);
        end

        // R9 unsupported opcode and zero counts
        r0 = rises;
        push_cmd(5'h05, 9'd3); wait_done();
        push_dat(8'h77);
        push_cmd(5'h08, 9'd0); wait_done();
        check(rises == r0 && spi_cs_n == 1'b0, "R9", rises - r0, 0);
        pop_dat(b);
        check(b == 8'h77 && dat_empty, "R9", b, 8'h77);

        // R7 send stall and R6 queue full / completion
        r0 = rises;
        push_cmd(5'h08, 9'd1);
        repeat (20) @(negedge clk);
        check(spi_sck == 1'b0 && rises == r0, "R7", rises - r0, 0);
        check(cmd_empty == 1'b0, "R6", cmd_empty, 0);
        push_cmd(5'h01, 9'd1); push_cmd(5'h01, 9'd1); push_cmd(5'h01, 9'd1);
        @(negedge clk);
        check(cmd_full == 1'b1, "R6", cmd_full, 1);
        cmd_wdata = {5'h00, 9'd1}; cmd_push = 1'b1;
        @(negedge clk); cmd_push = 1'b0;
        push_dat(8'h42);
        wait_done();
        check(spi_cs_n == 1'b0, "R6", spi_cs_n, 0);

        // R10 host pop ignored during send
        push_cmd(5'h08, 9'd1);
        push_dat(8'h11);
        push_dat(8'h22);
        @(negedge clk); dat_pop = 1'b1; @(negedge clk); dat_pop = 1'b0;
        wait_done();
        pop_dat(b);
        check(b == 8'h22 && dat_empty, "R10", b, 8'h22);

        // R10 host push ignored during receive
        rx_w = 0;
        rx_pat[0] = 8'hC9; rx_pat[1] = 8'h36;
        g = 0;
        push_cmd(5'h0C, 9'd2);
        repeat (4) @(negedge clk);
        dat_wdata = 8'hFF; dat_push = 1'b1; @(negedge clk); dat_push = 1'b0;
        wait_done();
        pop_dat(b); check(b == 8'hC9, "R4", b, 8'hC9);
        pop_dat(b); check(b == 8'h36, "R4", b, 8'h36);
        @(negedge clk);
        check(dat_empty, "R10", dat_empty, 1);

        // R8 receive stall when byte queue full
        rx_w = 2;
        for (int j = 0; j < 8; j++) rx_pat[j] = 8'(8'h30 + j * 8'h11);
        g = 0;
        push_cmd(5'h0F, 9'd6);
        repeat (60) @(negedge clk);
        r0 = rises;
        repeat (20) @(negedge clk);
        check(dat_full && !cmd_empty && rises == r0 && !spi_sck, "R8", rises - r0, 0);
        for (int j = 0; j < 6; j++) begin
            pop_dat(b);
            check(b == rx_pat[j], "R8", b, rx_pat[j]);
        end
        wait_done();
        check(dat_empty, "R8", dat_empty, 1);

        // R11 pop coinciding with a receiver write, phase sweep
        for (int off = 0; off < 5; off++) begin
            int bad;
            bad = 0;
            for (int j = 0; j < 8; j++) rx_pat[j] = 8'(8'h81 + j * 8'h13 + off);
            g = 0;
            push_cmd(5'h0F, 9'd6);
            @(negedge clk);
            while (dat_empty) @(negedge clk);
            repeat (off) @(negedge clk);
            for (int j = 0; j < 6; j++) begin
                pop_dat(b);
                if (b != rx_pat[j]) bad++;
                repeat (3) @(negedge clk);
            end
            wait_done();
            check(bad == 0 && dat_empty, "R11", bad, 0);
        end

        // R2 release chip select
        push_cmd(5'h00, 9'd1); wait_done();
        check(spi_cs_n == 1'b1, "R2", spi_cs_n, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule